// File: doc/BRIEF.md
# Memory-Mapped Configuration Window Decoder

This block holds the 64-bit control word that places the memory-mapped configuration window in the system address map. Software updates the word through a simple configuration write port that carries a dword index, 32 bits of data and four byte enables. Any write that enables at least one byte of either of the word's two dwords causes the block to derive the window again from the merged word: an enable flag, a size of 256, 128 or 64 MiB, and a base address. Incoming 64-bit memory addresses are then compared against the active window, and a hit output marks those that fall inside it.

The base is taken from address bits 38:28 of the control word. Each step down in window size brings one more low bit into the base: bit 27 at 128 MiB, and bits 27 and 26 at 64 MiB. The fourth length code is reserved. A write that leaves the reserved code in the word still stores the written bytes, but it leaves the active window exactly as it was and raises a one-cycle error pulse. At reset the word loads a fixed default and the window is derived from it.

Top module: `cfgwin_decoder`

## Requirements
- R1: Bit 0 of the control word is the enable; while the active window's enable is 0, `mem_hit` is 0 for every address.
- R2: Bits 2:1 of the control word select the size: 2'b00 gives 256 MiB, 2'b01 gives 128 MiB, 2'b10 gives 64 MiB, shown in bytes on `win_size`.
- R3: `win_base` equals control-word bits 38:28, plus bit 27 for 128 MiB, plus bits 27 and 26 for 64 MiB; every other bit of `win_base` is 0 whatever the word holds there.
- R4: When a write leaves code 2'b11 in bits 2:1, `win_en`, `win_base` and `win_size` keep their previous values and `len_err` is 1 for the cycle after that write.
- R5: The word occupies dword indices `REG_DW` (bits 31:0) and `REG_DW+1` (bits 63:32); a write updates exactly the bytes whose enable bit is set, and a write elsewhere or with all byte enables 0 changes no output.
- R6: After reset the word equals `RESET_VAL` (default 64'h0000_0000_B000_0000), so `win_en` is 0, `win_base` is 64'hB000_0000, `win_size` is 256 MiB and `len_err` is 0.
- R7: `mem_hit` is 1 exactly when `win_en` is 1 and `win_base` <= `mem_addr` < `win_base` + `win_size`; it is combinational from `mem_addr`.
- R8: A write is reflected on the window outputs in the cycle after the write strobe, and `len_err` stays high for only that one cycle unless the next cycle also carries a reserved-code write.
- R9: Each overlapping write recomputes from the whole merged word, so a write to the upper dword while bits 2:1 hold 2'b11 raises `len_err` again and leaves the window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wr_dwaddr | input | DWA_W | Dword index of the configuration write |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Byte enables, bit n selects data bits 8n+7:8n |
| mem_addr | input | 64 | Memory address to compare against the window |
| mem_hit | output | 1 | Address falls inside the enabled window |
| win_en | output | 1 | Active window enable |
| win_base | output | 64 | Active window base address |
| win_size | output | 32 | Active window size in bytes |
| len_err | output | 1 | One-cycle pulse after a write that leaves the reserved length code |

## Verification
On every cycle the assertions check that the active window's base is aligned to its size, that the size is one of the three legal values, that a cycle without an overlapping write leaves the window and error flag quiet, that a reserved-code write freezes the window and raises the error pulse, and that any hit lies inside the window and requires the enable. Only the bench's scenarios can show that the base bits land in the right positions for each size, that partial byte enables merge into the correct bytes, that writes to neighbouring dwords are ignored, and that the reset default produces the expected window. The bench sweeps every length code and enable against a set of base patterns, writing each dword separately so the mixed intermediate words are also decoded, and probes the window's edges on each result.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } win_len_e;

  typedef struct packed {
    logic        en;
    logic [63:0] base;
    logic [31:0] size;
  } win_t;

  // Derive a window from a control word. hi is the top base bit,
  // sh is log2 of the largest window size.
  function automatic win_t decode_win(input logic [63:0] word,
                                      input int hi, input int sh);
    win_t w;
    int   lo;
    case (win_len_e'(word[2:1]))
      LEN_128M: lo = sh - 1;
      LEN_64M:  lo = sh - 2;
      default:  lo = sh;
    endcase
    w.en   = word[0];
    w.size = 32'd1 << lo;
    for (int i = 0; i < 64; i++) begin
      w.base[i] = (i <= hi && i >= lo) ? word[i] : 1'b0;
    end
    return w;
  endfunction

endpackage

// File: rtl/cfgwin_word.sv
module cfgwin_word #(
  parameter int          DWA_W     = 10,
  parameter int          REG_DW    = 24,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DWA_W-1:0] wr_dwaddr,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_be,
  output logic [63:0]      word_d,
  output logic             upd
);

  localparam logic [DWA_W-1:0] DW_LO = DWA_W'(REG_DW);
  localparam logic [DWA_W-1:0] DW_HI = DWA_W'(REG_DW + 1);

  logic [63:0] word_q;
  logic        sel_lo, sel_hi;

  always_comb begin
    sel_lo = wr_en && (wr_dwaddr == DW_LO) && (|wr_be);
    sel_hi = wr_en && (wr_dwaddr == DW_HI) && (|wr_be);
    upd    = sel_lo || sel_hi;
    word_d = word_q;
    for (int b = 0; b < 4; b++) begin
      if (sel_lo && wr_be[b]) word_d[8*b +: 8]      = wr_data[8*b +: 8];
      if (sel_hi && wr_be[b]) word_d[32 + 8*b +: 8] = wr_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RESET_VAL;
    end else if (upd) begin
      word_q <= word_d;
    end
  end

  // R5: only one dword of the word can be selected by a write
  assert_one_dword_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_lo && sel_hi));

endmodule

// File: rtl/cfgwin_apply.sv
module cfgwin_apply
  import cfgwin_pkg::*;
#(
  parameter int          BASE_HI   = 38,
  parameter int          MAX_SH    = 28,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic [63:0] word_d,
  output win_t        win_q,
  output logic        len_err
);

  localparam win_t RST_WIN = decode_win(RESET_VAL, BASE_HI, MAX_SH);
  localparam logic [31:0] SZ_BIG = 32'd1 << MAX_SH;
  localparam logic [31:0] SZ_MID = 32'd1 << (MAX_SH - 1);
  localparam logic [31:0] SZ_SML = 32'd1 << (MAX_SH - 2);

  win_t     win_d;
  win_len_e len_nxt;
  logic     rsvd_wr, load, err_d;

  always_comb begin
    len_nxt = win_len_e'(word_d[2:1]);
    rsvd_wr = upd && (len_nxt == LEN_RSVD);
    load    = upd && !rsvd_wr;
    win_d   = load ? decode_win(word_d, BASE_HI, MAX_SH) : win_q;
    err_d   = rsvd_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= RST_WIN;
      len_err <= 1'b0;
    end else begin
      win_q   <= win_d;
      len_err <= err_d;
    end
  end

  // R4: a reserved-code write freezes the window and flags an error
  assert_rsvd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_wr |=> ($stable(win_q) && len_err));

  // R5: without an overlapping write nothing moves
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(win_q) && !len_err));

  // R2: size is always one of the three legal values
  assert_size_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q.size == SZ_BIG) || (win_q.size == SZ_MID) || (win_q.size == SZ_SML));

  // R3: base is aligned to the size and has no bits above the top base bit
  assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_q.base & ({32'd0, win_q.size} - 64'd1)) == 64'd0) &&
    ((win_q.base >> (BASE_HI + 1)) == 64'd0));

endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match
  import cfgwin_pkg::*;
(
  input  win_t        win,
  input  logic [63:0] addr,
  output logic        hit
);

  logic [63:0] low_mask;

  always_comb begin
    low_mask = {32'd0, win.size} - 64'd1;
    hit      = win.en && ((addr & ~low_mask) == win.base);
  end

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int          DWA_W     = 10,
  parameter int          REG_DW    = 24,
  parameter int          BASE_HI   = 38,
  parameter int          MAX_SH    = 28,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [DWA_W-1:0] cfg_wr_dwaddr,
  input  logic [31:0]      cfg_wr_data,
  input  logic [3:0]       cfg_wr_be,
  input  logic [63:0]      mem_addr,
  output logic             mem_hit,
  output logic             win_en,
  output logic [63:0]      win_base,
  output logic [31:0]      win_size,
  output logic             len_err
);

  logic [63:0] word_d;
  logic        upd;
  win_t        win_q;

  cfgwin_word #(
    .DWA_W     (DWA_W),
    .REG_DW    (REG_DW),
    .RESET_VAL (RESET_VAL)
  ) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_dwaddr (cfg_wr_dwaddr),
    .wr_data   (cfg_wr_data),
    .wr_be     (cfg_wr_be),
    .word_d    (word_d),
    .upd       (upd)
  );

  cfgwin_apply #(
    .BASE_HI   (BASE_HI),
    .MAX_SH    (MAX_SH),
    .RESET_VAL (RESET_VAL)
  ) u_apply (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .word_d  (word_d),
    .win_q   (win_q),
    .len_err (len_err)
  );

  cfgwin_match u_match (
    .win  (win_q),
    .addr (mem_addr),
    .hit  (mem_hit)
  );

  assign win_en   = win_q.en;
  assign win_base = win_q.base;
  assign win_size = win_q.size;

  // R1: no hit while the window is disabled
  assert_hit_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !mem_hit);

  // R7: any hit lies inside [base, base+size)
  assert_hit_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> ((mem_addr >= win_base) &&
                 (mem_addr < (win_base + {32'd0, win_size}))));

endmodule

// File: tb/cfgwin_decoder_tb.sv
module cfgwin_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DWA_W      = 10;
  localparam int REG_DW     = 24;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_wr_en;
  logic [DWA_W-1:0] cfg_wr_dwaddr;
  logic [31:0]      cfg_wr_data;
  logic [3:0]       cfg_wr_be;
  logic [63:0]      mem_addr;
  logic             mem_hit;
  logic             win_en;
  logic [63:0]      win_base;
  logic [31:0]      win_size;
  logic             len_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench model
  logic [63:0] m_word;
  logic        m_en;
  logic [63:0] m_base;
  logic [63:0] m_size;
  logic        m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgwin_decoder #(.DWA_W(DWA_W), .REG_DW(REG_DW)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_dwaddr (cfg_wr_dwaddr),
    .cfg_wr_data   (cfg_wr_data),
    .cfg_wr_be     (cfg_wr_be),
    .mem_addr      (mem_addr),
    .mem_hit       (mem_hit),
    .win_en        (win_en),
    .win_base      (win_base),
    .win_size      (win_size),
    .len_err       (len_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_word = 64'h0000_0000_B000_0000;
    m_en   = 1'b0;
    m_base = 64'hB000_0000;
    m_size = 64'd1 << 28;
    m_err  = 1'b0;
  endtask

  task automatic model_write(input int dw, input logic [31:0] d, input logic [3:0] be);
    logic [1:0] len;
    m_err = 1'b0;
    if ((dw == REG_DW || dw == REG_DW + 1) && be != 4'd0) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) m_word[(dw - REG_DW)*32 + 8*b +: 8] = d[8*b +: 8];
      len = m_word[2:1];
      if (len == 2'b11) begin
        m_err = 1'b1;
      end else begin
        m_en   = m_word[0];
        m_size = 64'd1 << (28 - len);
        m_base = m_word & ~(m_size - 64'd1) & ((64'd1 << 39) - 64'd1);
      end
    end
  endtask

  task automatic check_window(input string r);
    chk({r, " win_en"},   {63'd0, win_en}, {63'd0, m_en});
    chk({r, " win_base"}, win_base, m_base);
    chk({r, " win_size"}, {32'd0, win_size}, m_size);
  endtask

  task automatic probe(input logic [63:0] a);
    logic exp;
    mem_addr = a;
    #1;
    exp = m_en && (a >= m_base) && (a < m_base + m_size);
    chk(m_en ? "R7 mem_hit" : "R1 mem_hit", {63'd0, mem_hit}, {63'd0, exp});
  endtask

  task automatic probe_edges();
    probe(m_base);
    probe(m_base + m_size - 64'd1);
    probe(m_base + m_size);
    probe(m_base - 64'd1);
    probe(m_base ^ (64'd1 << 27));
    probe(m_base ^ (64'd1 << 26));
    probe(m_base | (64'd1 << 40));
  endtask

  // one write, then checks in the following cycle and the one after
  task automatic do_write(input int dw, input logic [31:0] d, input logic [3:0] be,
                          input string r);
    @(negedge clk);
    cfg_wr_en     = 1'b1;
    cfg_wr_dwaddr = DWA_W'(dw);
    cfg_wr_data   = d;
    cfg_wr_be     = be;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(dw, d, be);
    chk({r, " R8 len_err after write"}, {63'd0, len_err}, {63'd0, m_err});
    check_window(r);
    probe_edges();
    @(negedge clk);
    chk("R8 len_err one cycle", {63'd0, len_err}, 64'd0);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R6 len_err reset", {63'd0, len_err}, 64'd0);
    check_window("R6");
    probe_edges();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL R8 watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [6];
    logic [63:0] v;
    pats[0] = 64'h0000_0000_B000_0000;
    pats[1] = 64'h0000_007F_FC00_0000;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFF8;
    pats[3] = 64'h0000_0012_3400_0000;
    pats[4] = 64'h0000_0040_0000_0000;
    pats[5] = 64'h0000_0000_0C00_0000;
    cfg_wr_en = 1'b0; cfg_wr_dwaddr = '0; cfg_wr_data = '0; cfg_wr_be = '0;
    mem_addr = '0;
    apply_reset();

    // R2 R3 R4 R9: every length code and enable against each pattern,
    // low dword first, then high dword
    for (int len = 0; len < 4; len++) begin
      for (int en = 0; en < 2; en++) begin
        for (int p = 0; p < 6; p++) begin
          v = (pats[p] & ~64'd7) | (64'(len) << 1) | 64'(en);
          do_write(REG_DW, v[31:0], 4'hF, len == 3 ? "R4 low" : "R2 R3 low");
          do_write(REG_DW + 1, v[63:32], 4'hF, len == 3 ? "R9 high" : "R3 high");
        end
      end
    end

    // R5: byte-enable sweep on both dwords
    do_write(REG_DW + 1, 32'h0000_0000, 4'hF, "R5 clear high");
    for (int be = 0; be < 16; be++) begin
      do_write(REG_DW, 32'h5A3C_1E0F ^ {be[3:0], 28'd0}, 4'(be), "R5 low be");
      do_write(REG_DW, 32'h0000_0001, 4'h1, "R5 low restore");
      do_write(REG_DW + 1, 32'h0000_0025 + 32'(be), 4'(be), "R5 high be");
    end

    // R5: neighbouring dwords and empty byte enables change nothing
    do_write(REG_DW, 32'hA000_0003, 4'hF, "R5 setup");
    do_write(REG_DW - 1, 32'hFFFF_FFFF, 4'hF, "R5 below");
    do_write(REG_DW + 2, 32'hFFFF_FFFF, 4'hF, "R5 above");
    do_write(REG_DW, 32'hFFFF_FFFF, 4'h0, "R5 be zero");

    // R8: back-to-back reserved writes keep the flag up each cycle
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_dwaddr = DWA_W'(REG_DW); cfg_wr_data = 32'h0000_0007; cfg_wr_be = 4'h1;
    @(negedge clk);
    model_write(REG_DW, 32'h0000_0007, 4'h1);
    cfg_wr_dwaddr = DWA_W'(REG_DW + 1); cfg_wr_data = 32'h0000_0011; cfg_wr_be = 4'hF;
    chk("R8 len_err first", {63'd0, len_err}, 64'd1);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(REG_DW + 1, 32'h0000_0011, 4'hF);
    chk("R8 len_err second", {63'd0, len_err}, 64'd1);
    check_window("R4 after pair");
    @(negedge clk);
    chk("R8 len_err drops", {63'd0, len_err}, 64'd0);

    // R6: reset in the middle of operation restores the default window
    do_write(REG_DW, 32'h1400_0005, 4'hF, "R6 pre");
    apply_reset();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule